// File: doc/BRIEF.md
# Two-Band Polyphase Sub-Band Synthesis Filter

This block rebuilds a full-rate sample stream from two half-rate sub-band streams, one low band and one high band. Each arriving pair first passes through an inverse two-point butterfly, which forms the sum and the difference of the two band samples. Each of the two results then enters its own 16-tap polyphase branch of a 32-tap mirror-symmetric prototype low-pass filter. The difference branch uses the even-indexed coefficients and the sum branch uses the odd-indexed ones. Because of this split, the high band is in effect filtered by the negated high-pass mirror of the prototype, and aliasing from the analysis side cancels.

A full-rate strobe `tick` paces the block. A band pair is accepted only on a tick where `pair_valid` is also high. On that tick both branch results are computed. The difference-branch sample goes out first, and the sum-branch sample is held in a register until the next tick. Each branch result is an accumulation in Q(`FRAC`) format. It is scaled by the interpolation gain of two, rounded half-up, and saturated to the output width.

Top module: `qmf_synth_bank`

## Requirements
- R1: While `rst_n` is low, the next clock edge sets `out` to 0 and `out_valid` to 0, and clears both branch delay lines, so the first pair after reset sees only zero history.
- R2: `out_valid` is high in the cycle after a clock edge on which `tick` was high, and low after any edge on which `tick` was low.
- R3: On a tick with `pair_valid` high, `out` becomes the difference-branch result: sum over j=0..15 of h(2j)*(lo-hi) taken j pairs back, where j=0 is the pair now arriving.
- R4: On a tick with `pair_valid` low, `out` becomes the held sum-branch result of the most recent pair: sum over j=0..15 of h(2j+1)*(lo+hi) taken j pairs back.
- R5: With the default coefficients h(0..15) = 21, -69, -35, 164, 55, -331, -65, 594, 45, -1006, 30, 1675, -240, -2955, 4800, 13701 (Q15) and h(31-k)=h(k), a low-band impulse of 16384 with the high band at 0, preceded and followed by zero pairs, yields the output sequence h(0), h(1), ..., h(31).
- R6: A high-band impulse of 16384 with the low band at 0 yields the output sequence (-1)^(n+1)*h(n) for n=0..31, that is, the negated mirror high-pass response.
- R7: A result outside the signed 16-bit range is clamped to 32767 or -32768.
- R8: Each output equals floor((acc + 2^13) / 2^14), where acc is the branch sum of products in Q15. This is a gain of two followed by rounding half toward plus infinity.
- R9: A high `pair_valid` with `tick` low is ignored: `out`, `out_valid` and both delay lines are left unchanged.
- R10: Between ticks `out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Full-rate sample strobe |
| pair_valid | input | 1 | Band pair present on this tick |
| lo_in | input | 16 | Low-band sample, signed |
| hi_in | input | 16 | High-band sample, signed |
| out | output | 16 | Reconstructed sample, signed |
| out_valid | output | 1 | High for one cycle after each tick |

## Verification
Every result appears on `out` exactly one clock edge after the tick that produces it. The difference-branch sample follows the pair tick, and the sum-branch sample follows the next tick, however many idle cycles lie between the two ticks. The bench changes inputs on the falling edge and reads `out` and `out_valid` at the following falling edge, which is half a period after the edge that updated them. During idle gaps it re-reads `out` on every falling edge to confirm the held value. A bench-side model, built from the requirement formulas, predicts each of the two outputs for every pair.

// File: rtl/qmf_synth_bank.sv
module qmf_synth_bank #(
  parameter int W    = 16,
  parameter int CW   = 16,
  parameter int TAPS = 32,
  parameter int FRAC = 15,
  parameter logic signed [CW-1:0] COEF [0:TAPS/2-1] = '{
    16'sd21, -16'sd69, -16'sd35, 16'sd164, 16'sd55, -16'sd331, -16'sd65, 16'sd594,
    16'sd45, -16'sd1006, 16'sd30, 16'sd1675, -16'sd240, -16'sd2955, 16'sd4800, 16'sd13701}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                pair_valid,
  input  logic signed [W-1:0] lo_in,
  input  logic signed [W-1:0] hi_in,
  output logic signed [W-1:0] out,
  output logic                out_valid
);
  localparam int PH = TAPS / 2;
  localparam int AW = W + 1 + CW + $clog2(PH) + 2;
  localparam logic signed [W-1:0] YMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] YMIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0]    sum_hist [0:PH-2];
  logic signed [W:0]    dif_hist [0:PH-2];
  logic signed [W:0]    sum_new, dif_new;
  logic signed [AW-1:0] acc_e, acc_o;
  logic signed [W-1:0]  y_e, y_o, held;
  logic                 take;

  assign take    = tick && pair_valid;
  assign sum_new = W'(lo_in) + (W+1)'(hi_in);
  assign dif_new = (W+1)'(lo_in) - (W+1)'(hi_in);

  function automatic logic signed [CW-1:0] hval(input int k);
    return (k < PH) ? COEF[k] : COEF[TAPS-1-k];
  endfunction

  function automatic logic signed [W-1:0] scale(input logic signed [AW-1:0] acc);
    logic signed [AW-1:0] t;
    t = (acc + (AW'(1) <<< (FRAC-2))) >>> (FRAC-1);
    if (t > AW'(YMAX)) return YMAX;
    if (t < AW'(YMIN)) return YMIN;
    return t[W-1:0];
  endfunction

  always_comb begin
    acc_e = AW'(dif_new) * AW'(hval(0));
    acc_o = AW'(sum_new) * AW'(hval(1));
    for (int j = 1; j < PH; j++) begin
      acc_e = acc_e + AW'(dif_hist[j-1]) * AW'(hval(2*j));
      acc_o = acc_o + AW'(sum_hist[j-1]) * AW'(hval(2*j+1));
    end
  end

  assign y_e = scale(acc_e);
  assign y_o = scale(acc_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PH-1; i++) begin
        sum_hist[i] <= '0;
        dif_hist[i] <= '0;
      end
    end else if (take) begin
      sum_hist[0] <= sum_new;
      dif_hist[0] <= dif_new;
      for (int i = 1; i < PH-1; i++) begin
        sum_hist[i] <= sum_hist[i-1];
        dif_hist[i] <= dif_hist[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out       <= '0;
      held      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= tick;
      if (take) begin
        out  <= y_e;
        held <= y_o;
      end else if (tick) begin
        out <= held;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (out == '0 && !out_valid));

  assert_valid_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> out_valid);

  assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !out_valid);

  assert_second_from_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pair_valid) |=> out == $past(held));

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out));
endmodule

// File: tb/sim_qmf_synth_bank.sv
`timescale 1ns/1ps
module sim_qmf_synth_bank;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pair_valid = 1'b0;
  logic signed [15:0] lo_in = '0, hi_in = '0;
  logic signed [15:0] out;
  logic out_valid;
  int checks = 0, errors = 0;
  int hs [0:31];
  longint ms [0:15];
  longint md [0:15];

  always #2.5 clk = ~clk;

  qmf_synth_bank u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .pair_valid(pair_valid),
                     .lo_in(lo_in), .hi_in(hi_in), .out(out), .out_valid(out_valid));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fit(input longint acc);
    longint t = (acc + 8192) >>> 14;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin ms[i] = 0; md[i] = 0; end
  endtask

  task automatic model_push(input int lo, input int hi, output int e, output int o);
    longint ae = 0, ao = 0;
    for (int i = 15; i > 0; i--) begin ms[i] = ms[i-1]; md[i] = md[i-1]; end
    ms[0] = lo + hi;
    md[0] = lo - hi;
    for (int j = 0; j < 16; j++) begin
      ae += md[j] * hs[2*j];
      ao += ms[j] * hs[2*j+1];
    end
    e = fit(ae);
    o = fit(ao);
  endtask

  task automatic pair_cycle(input int lo, input int hi, input int gap, input string req,
                            output int ae, output int ao);
    int e, o;
    model_push(lo, hi, e, o);
    @(negedge clk);
    tick = 1'b1; pair_valid = 1'b1; lo_in = 16'(lo); hi_in = 16'(hi);
    @(negedge clk);
    tick = 1'b0; pair_valid = 1'b0;
    ae = out;
    check(out == 16'(e), {req, " first"}, out, e);
    check(out_valid, "R2 valid after pair tick", out_valid, 1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(out == 16'(e) && !out_valid, "R10 hold/R2 idle", out, e);
    end
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    ao = out;
    check(out == 16'(o), {req, " second"}, out, o);
    check(out_valid, "R2 valid after second tick", out_valid, 1);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(out == 16'(o) && !out_valid, "R10 hold/R2 idle", out, o);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; pair_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out == 0, "R1 out cleared", out, 0);
    check(!out_valid, "R1 valid cleared", out_valid, 0);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic test_lo_impulse();
    int a, b;
    for (int k = 0; k < 6; k++) pair_cycle(7000 * (k - 2), 3000 - 1500 * k, 0, "R3/R4 warmup", a, b);
    do_reset();
    for (int m = 0; m < 16; m++) begin
      pair_cycle(m == 0 ? 16384 : 0, 0, 0, "R3/R4 lo impulse", a, b);
      check(a == hs[2*m], "R5 even tap (R1 history cleared)", a, hs[2*m]);
      check(b == hs[2*m+1], "R5 odd tap", b, hs[2*m+1]);
    end
  endtask

  task automatic test_hi_impulse();
    int a, b;
    do_reset();
    for (int m = 0; m < 16; m++) begin
      pair_cycle(0, m == 0 ? 16384 : 0, 1, "R3/R4 hi impulse", a, b);
      check(a == -hs[2*m], "R6 even tap negated", a, -hs[2*m]);
      check(b == hs[2*m+1], "R6 odd tap", b, hs[2*m+1]);
    end
  endtask

  task automatic test_saturation();
    int a, b;
    do_reset();
    for (int m = 0; m < 18; m++) pair_cycle(32767, 32767, 0, "R7 positive", a, b);
    check(b == 32767, "R7 clamp high", b, 32767);
    check(a == 0, "R7 zero difference", a, 0);
    for (int m = 0; m < 18; m++) pair_cycle(-32768, -32768, 0, "R7 negative", a, b);
    check(b == -32768, "R7 clamp low", b, -32768);
  endtask

  task automatic test_rounding();
    int a, b;
    do_reset();
    pair_cycle(-12345, 0, 0, "R8 neg impulse", a, b);
    check(a == fit(-12345 * 21), "R8 rounding h0", a, fit(-12345 * 21));
    for (int m = 1; m < 16; m++) pair_cycle(0, 0, 0, "R8 tail", a, b);
    for (int m = 0; m < 12; m++) pair_cycle(m * 2731 - 15000, 11111 - m * 1913, 0, "R8 mixed", a, b);
  endtask

  task automatic test_ignore();
    int a, b, keep;
    do_reset();
    pair_cycle(1000, -500, 0, "R9 before", a, b);
    keep = b;
    @(negedge clk);
    pair_valid = 1'b1; tick = 1'b0; lo_in = 16'sd30000; hi_in = -16'sd30000;
    repeat (3) @(negedge clk);
    check(out == 16'(keep) && !out_valid, "R9 stray pair ignored", out, keep);
    pair_valid = 1'b0;
    for (int m = 0; m < 4; m++) pair_cycle(-700 * m, 250 * m, 0, "R9 history intact", a, b);
  endtask

  task automatic test_gaps();
    int a, b;
    do_reset();
    for (int m = 0; m < 8; m++) pair_cycle(4096 - 900 * m, 2048 * (m % 3) - 2048, m % 4, "R10 gapped", a, b);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base [0:15] = '{21, -69, -35, 164, 55, -331, -65, 594,
                        45, -1006, 30, 1675, -240, -2955, 4800, 13701};
    for (int k = 0; k < 16; k++) begin hs[k] = base[k]; hs[31-k] = base[k]; end
    model_clear();
    do_reset();
    test_lo_impulse();
    test_hi_impulse();
    test_saturation();
    test_rounding();
    test_ignore();
    test_gaps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule